// File: doc/BRIEF.md
# Reset Sequence Generator with Pin Stretch

This block turns a set of reset requests into the single internal reset of the chip. The requests are power-on, low supply voltage, clock loss, watchdog expiry and an active-low reset pin that is shared with the board. Any internal request starts a sequence of fixed length. Internal reset is held for the whole sequence. For the first part of the sequence the block pulls the shared pin low, so that devices elsewhere on the board see the reset as well.

After the drive phase the block lets go of the pin and reads it back through a synchronizer. If something on the board still holds the pin low when the sequence reaches its end, internal reset is held on until the pin reads high again. A low level on the pin while no reset is in progress starts a sequence of its own. A cause register records what started the current reset. An asynchronous power-on forces that register to a known value.

Top module: `rst_seq_gen`

## Requirements
- R1: A one-cycle internal request (low voltage, clock loss or watchdog) raises sys_rst on the next cycle. When the pin reads high at the end, sys_rst stays high for exactly TOTAL_CYC (192) consecutive cycles.
- R2: pin_drive_low is high for the first DRIVE_CYC (128) cycles of the sequence and then falls while sys_rst is still high. It does not rise again unless a new request arrives.
- R3: When no reset is in progress, the pin held low starts a sequence. sys_rst rises SYNC_STAGES+1 (3) cycles after the pin goes low, and the sequence then has the same length and drive phase as in R1 and R2.
- R4: If the synchronized pin still reads low at the last cycle of the sequence, sys_rst holds until the pin is seen high. When the pin goes high at sequence cycle k, counting the first reset cycle as 0, sys_rst lasts max(192, k+3) cycles.
- R5: An internal request that arrives while a sequence runs, including in its last cycle, restarts the sequence from its first cycle, drive phase included.
- R6: rst_cause bits are: bit 0 power-on, bit 1 low voltage, bit 2 clock loss, bit 3 watchdog, bit 4 external pin. A sequence started from idle replaces rst_cause with the sources that started it.
- R7: Requests that arrive during a running sequence are ORed into rst_cause.
- R8: Bit 4 is set only when the pin starts a sequence with no internal request in that cycle. A pin low seen in the same cycle as an internal request leaves bit 4 clear.
- R9: por_req forces rst_cause to 5'b00001 at once, without waiting for a clock edge. It also acts as a request: the sequence runs 192 cycles, counting from the last clock with por_req high.
- R10: When the sequence ends, the pin released by the block does not start a new reset. sys_rst stays low while the pin stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request. Active high. Clears the cause register asynchronously. |
| lvr_req | input | 1 | Low-voltage request, synchronous |
| clkmon_req | input | 1 | Clock-loss request, synchronous |
| wdog_req | input | 1 | Watchdog request, synchronous |
| pin_in | input | 1 | Level sampled from the shared reset pin (low means reset) |
| sys_rst | output | 1 | Internal reset, active high |
| pin_drive_low | output | 1 | Enable that pulls the shared reset pin low |
| rst_cause | output | 5 | Reset cause flags (see R6) |

## Verification
Two events can fall in the same cycle. The first is the end of the sequence and a fresh internal request. The bench sweeps the injection point over the whole sequence, including its final cycle, and expects a restart with a total length of j+1+192. The second is an external low reaching the state machine in the same cycle as an internal request from idle. The bench sets this up by lowering the pin two cycles before a watchdog pulse, and it judges the result by the cause register, which must show the watchdog alone. The stretch boundary is swept one cycle at a time around the end of the sequence and compared against max(192, k+3).

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int NUM_CAUSE = 5;
  localparam int C_POR    = 0;
  localparam int C_LVR    = 1;
  localparam int C_CLKMON = 2;
  localparam int C_WDOG   = 3;
  localparam int C_EXT    = 4;
  typedef logic [NUM_CAUSE-1:0] cause_t;
  localparam cause_t CAUSE_POR_ONLY = cause_t'(1 << C_POR);
endpackage

// File: rtl/rsg_pin_sync.sv
module rsg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic srst,
  input  logic pin_raw,
  output logic pin_sync
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (srst) chain[0] <= 1'b1;
        else      chain[0] <= pin_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (srst) chain[i] <= 1'b1;
        else      chain[i] <= chain[i-1];
      end
    end
  end

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/rsg_seq.sv
module rsg_seq #(
  parameter int TOTAL_CYC = 192,
  parameter int DRIVE_CYC = 128
) (
  input  logic clk,
  input  logic srst,
  input  logic req_int,
  input  logic pin_low,
  output logic rst_active,
  output logic drive_low,
  output logic start,
  output logic ext_start
);
  localparam int CNT_W = $clog2(TOTAL_CYC);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TOTAL_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_LIM  = CNT_W'(DRIVE_CYC);

  logic             active_q, nxt_active;
  logic [CNT_W-1:0] cnt_q, nxt_cnt;
  logic             drive_q;

  always_comb begin
    ext_start  = !active_q && pin_low && !req_int;
    start      = req_int || ext_start;
    nxt_active = active_q;
    nxt_cnt    = cnt_q;
    if (start) begin
      nxt_active = 1'b1;
      nxt_cnt    = '0;
    end else if (active_q) begin
      if (cnt_q == LAST_CNT) begin
        if (!pin_low) nxt_active = 1'b0;
      end else begin
        nxt_cnt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      drive_q  <= 1'b1;
    end else begin
      active_q <= nxt_active;
      cnt_q    <= nxt_cnt;
      drive_q  <= nxt_active && (nxt_cnt < DRV_LIM);
    end
  end

  assign rst_active = active_q;
  assign drive_low  = drive_q;
endmodule

// File: rtl/rsg_cause.sv
module rsg_cause
  import rsg_pkg::*;
(
  input  logic   clk,
  input  logic   por_async,
  input  logic   start,
  input  logic   seq_idle,
  input  cause_t src,
  output cause_t cause_q
);
  always_ff @(posedge clk or posedge por_async) begin
    if (por_async)   cause_q <= CAUSE_POR_ONLY;
    else if (start)  cause_q <= seq_idle ? src : (cause_q | src);
  end
endmodule

// File: rtl/rst_seq_gen.sv
module rst_seq_gen
  import rsg_pkg::*;
#(
  parameter int TOTAL_CYC   = 192,
  parameter int DRIVE_CYC   = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       lvr_req,
  input  logic       clkmon_req,
  input  logic       wdog_req,
  input  logic       pin_in,
  output logic       sys_rst,
  output logic       pin_drive_low,
  output logic [4:0] rst_cause
);
  logic   pin_sync;
  logic   req_int;
  logic   active;
  logic   start;
  logic   ext_start;
  cause_t src;
  cause_t cause_q;

  rsg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .srst     (por_req),
    .pin_raw  (pin_in),
    .pin_sync (pin_sync)
  );

  assign req_int = por_req | lvr_req | clkmon_req | wdog_req;

  rsg_seq #(.TOTAL_CYC(TOTAL_CYC), .DRIVE_CYC(DRIVE_CYC)) u_seq (
    .clk        (clk),
    .srst       (por_req),
    .req_int    (req_int),
    .pin_low    (!pin_sync),
    .rst_active (active),
    .drive_low  (pin_drive_low),
    .start      (start),
    .ext_start  (ext_start)
  );

  always_comb begin
    src           = '0;
    src[C_POR]    = por_req;
    src[C_LVR]    = lvr_req;
    src[C_CLKMON] = clkmon_req;
    src[C_WDOG]   = wdog_req;
    src[C_EXT]    = ext_start;
  end

  rsg_cause u_cause (
    .clk       (clk),
    .por_async (por_req),
    .start     (start),
    .seq_idle  (!active),
    .src       (src),
    .cause_q   (cause_q)
  );

  assign sys_rst   = active;
  assign rst_cause = cause_q;
endmodule

// File: rtl/rst_seq_gen_chk.sv
module rst_seq_gen_chk #(
  parameter int TOTAL_CYC = 192
) (
  input logic clk,
  input logic por_req,
  input logic lvr_req,
  input logic clkmon_req,
  input logic wdog_req,
  input logic sys_rst,
  input logic pin_drive_low,
  input logic ext_flag
);
  logic [15:0] run_len;
  logic        any_req;

  assign any_req = lvr_req | clkmon_req | wdog_req;

  always_ff @(posedge clk) begin
    if (por_req || !sys_rst) run_len <= '0;
    else if (run_len != 16'hFFFF) run_len <= run_len + 1'b1;
  end

  // R2
  drive_in_rst_chk: assert property (@(posedge clk) disable iff (por_req)
    pin_drive_low |-> sys_rst);

  // R1
  req_start_chk: assert property (@(posedge clk) disable iff (por_req)
    any_req |=> (sys_rst && pin_drive_low));

  // R1
  min_len_chk: assert property (@(posedge clk) disable iff (por_req)
    $fell(sys_rst) |-> (run_len >= 16'(TOTAL_CYC)));

  // R2
  no_redrive_chk: assert property (@(posedge clk) disable iff (por_req)
    (sys_rst && !pin_drive_low && !any_req) |=> !pin_drive_low);

  // R8
  ext_flag_chk: assert property (@(posedge clk) disable iff (por_req)
    $rose(ext_flag) |-> $past(!any_req));
endmodule

bind rst_seq_gen rst_seq_gen_chk #(.TOTAL_CYC(TOTAL_CYC)) u_chk (
  .clk           (clk),
  .por_req       (por_req),
  .lvr_req       (lvr_req),
  .clkmon_req    (clkmon_req),
  .wdog_req      (wdog_req),
  .sys_rst       (sys_rst),
  .pin_drive_low (pin_drive_low),
  .ext_flag      (rst_cause[4])
);

// File: tb/rst_seq_gen_tb.sv
module rst_seq_gen_tb;
  localparam int TOTAL = 192;
  localparam int DRIVE = 128;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  logic por = 1'b1, lvr = 1'b0, cmon = 1'b0, wdog = 1'b0, ext_low = 1'b0;
  logic sys_rst, drv;
  logic [4:0] cause;
  logic pin;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  assign pin = !(drv | ext_low);

  always #5 clk = ~clk;

  rst_seq_gen #(.TOTAL_CYC(TOTAL), .DRIVE_CYC(DRIVE), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .por_req(por), .lvr_req(lvr), .clkmon_req(cmon), .wdog_req(wdog),
    .pin_in(pin), .sys_rst(sys_rst), .pin_drive_low(drv), .rst_cause(cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_req(input int which, input logic v);
    case (which)
      1: lvr  = v;
      2: cmon = v;
      3: wdog = v;
      default: ;
    endcase
  endtask

  task automatic pulse(input int which);
    @(negedge clk); set_req(which, 1'b1);
    @(negedge clk); set_req(which, 1'b0);
  endtask

  // counts reset cycles from a negedge showing the first sequence cycle
  task automatic run_seq(input int rel, input int inj, input int which,
                         output int rl, output int dl);
    int idx;
    idx = 0; dl = 0;
    while (sys_rst && idx < 2000) begin
      if (idx == rel) ext_low = 1'b0;
      if (idx == inj) set_req(which, 1'b1);
      if (idx == inj + 1) set_req(which, 1'b0);
      if (drv) dl++;
      idx++;
      @(negedge clk);
    end
    set_req(which, 1'b0);
    ext_low = 1'b0;
    rl = idx;
  endtask

  task automatic idle_check(input string req);
    int hi;
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sys_rst || drv) hi++;
    end
    check(hi == 0, req, hi, 0);
  endtask

  initial begin
    int rl, dl, lat, exp_rl, exp_dl;
    repeat (3) @(negedge clk);
    check(sys_rst == 1'b1 && drv == 1'b1, "R9 reset state", int'({sys_rst, drv}), 3);
    check(cause == 5'b00001, "R9 cause on por", int'(cause), 1);
    por = 1'b0;
    run_seq(-1, -1, 0, rl, dl);
    check(rl == TOTAL, "R9 R1 por length", rl, TOTAL);
    check(dl == DRIVE, "R2 por drive", dl, DRIVE);
    check(cause == 5'b00001, "R9 cause kept", int'(cause), 1);
    idle_check("R10 idle after por");

    for (int s = 1; s <= 3; s++) begin
      pulse(s);
      check(sys_rst && drv, "R1 immediate start", int'({sys_rst, drv}), 3);
      run_seq(-1, -1, 0, rl, dl);
      check(rl == TOTAL, "R1 length", rl, TOTAL);
      check(dl == DRIVE, "R2 drive length", dl, DRIVE);
      check(cause == 5'(1 << s), "R6 cause replaced", int'(cause), 1 << s);
      idle_check("R10 idle");
    end

    // external start from idle
    @(negedge clk); ext_low = 1'b1; lat = 0;
    while (!sys_rst && lat < 20) begin @(negedge clk); lat++; end
    check(lat == SYNC + 1, "R3 ext latency", lat, SYNC + 1);
    run_seq(2, -1, 0, rl, dl);
    check(rl == TOTAL, "R3 ext length", rl, TOTAL);
    check(dl == DRIVE, "R3 ext drive", dl, DRIVE);
    check(cause == 5'b10000, "R8 R6 ext cause", int'(cause), 16);
    idle_check("R10 idle after ext");

    // stretch sweep; pin low reaches logic in the same cycle as the request
    for (int k = 180; k <= 201; k++) begin
      @(negedge clk); ext_low = 1'b1;
      @(negedge clk);
      @(negedge clk); wdog = 1'b1;
      @(negedge clk); wdog = 1'b0;
      run_seq(k, -1, 0, rl, dl);
      exp_rl = (k + 3 > TOTAL) ? k + 3 : TOTAL;
      check(rl == exp_rl, "R4 stretch length", rl, exp_rl);
      check(dl == DRIVE, "R2 drive under stretch", dl, DRIVE);
      check(cause == 5'b01000, "R8 no ext flag", int'(cause), 8);
    end
    @(negedge clk); ext_low = 1'b1;
    @(negedge clk); @(negedge clk); lvr = 1'b1;
    @(negedge clk); lvr = 1'b0;
    run_seq(500, -1, 0, rl, dl);
    check(rl == 503, "R4 long stretch", rl, 503);
    idle_check("R10 idle after stretch");

    // restart sweep
    foreach (rl_pts[i]) ;
    for (int t = 0; t < 8; t++) begin
      int j;
      case (t)
        0: j = 0; 1: j = 5; 2: j = 126; 3: j = 127;
        4: j = 128; 5: j = 150; 6: j = 190; default: j = 191;
      endcase
      pulse(3);
      run_seq(-1, j, 2, rl, dl);
      exp_rl = j + 1 + TOTAL;
      exp_dl = (j < DRIVE) ? j + 1 + DRIVE : 2 * DRIVE;
      check(rl == exp_rl, "R5 restart length", rl, exp_rl);
      check(dl == exp_dl, "R5 restart drive", dl, exp_dl);
      check(cause == 5'b01100, "R7 cause ORed", int'(cause), 12);
    end
    pulse(1);
    run_seq(-1, -1, 0, rl, dl);
    check(cause == 5'b00010, "R6 replaced after OR", int'(cause), 2);

    // asynchronous por during a sequence
    pulse(3);
    repeat (10) @(negedge clk);
    #1 por = 1'b1;
    #1 check(cause == 5'b00001, "R9 async clear", int'(cause), 1);
    @(negedge clk); @(negedge clk); por = 1'b0;
    run_seq(-1, -1, 0, rl, dl);
    check(rl == TOTAL, "R9 length after por", rl, TOTAL);
    idle_check("R10 final idle");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  int rl_pts[1];

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule